// File: doc/BRIEF.md
# Interrupt Input Acquisition Stage

This block collects a vector of interrupt lines for a single CPU interrupt level and reduces them to one level-sensitive, active-high request. Every line is first brought into the block clock domain through a two-register synchronizer. A per-line detector then looks for an event. Each line has its own trigger-mode bit that selects level or edge detection, and its own polarity bit that selects the rising or the falling edge. A detected event latches a pending bit. The pending bits, gated by a per-line enable mask, are ORed into the request.

The CPU clears a pending bit with a one-cycle acknowledge that carries the line index. Line 0 is never driven and is held inactive throughout. The pending vector is also brought out, so that a downstream priority resolver can pick the line to service. Priority, vector generation and register access belong to neighbouring blocks.

Top module: `irq_acq_stage`

## Requirements
- R1: During and right after synchronous reset (rst_n low), every bit of pend_o is 0 and irq_req is 0.
- R2: A change on irq_raw[i] can reach pend_o[i] no earlier than the third rising clock edge after the change: two synchronizer edges and one pending-register edge.
- R3: trig_level[i] = 0 selects edge detection for line i, and trig_level[i] = 1 selects level detection. All-zero configuration inputs mean rising-edge detection.
- R4: In edge mode, edge_fall[i] = 0 detects only a 0-to-1 transition and edge_fall[i] = 1 detects only a 1-to-0 transition. The opposite transition leaves pend_o[i] unchanged.
- R5: In level mode, a synchronized high level sets pend_o[i]. If the line is still high when the acknowledge for i arrives, pend_o[i] stays set and the request is raised again.
- R6: In edge mode, a line held at a constant level after its edge does not set pend_o[i] again once the bit has been acknowledged.
- R7: ack_valid with ack_idx = i clears pend_o[i] at the next edge and leaves every other bit unchanged. An ack_idx at or above the line count changes nothing.
- R8: When a new event on line i and the acknowledge of i fall in the same cycle, pend_o[i] remains set.
- R9: irq_req is high exactly when some line is both pending and enabled (irq_en[i] = 1). Clearing an enable drops the request in the same cycle, with no clock edge, and keeps the pending bit.
- R10: pend_o[0] is never set, whatever is driven on irq_raw[0] or selected for line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_raw | input | N_IRQ | Raw interrupt lines, possibly asynchronous |
| trig_level | input | N_IRQ | Per-line mode: 0 edge, 1 level |
| edge_fall | input | N_IRQ | Per-line edge polarity: 0 rising, 1 falling |
| irq_en | input | N_IRQ | Per-line enable: 1 lets the pending bit drive the request |
| ack_valid | input | 1 | One-cycle acknowledge strobe |
| ack_idx | input | $clog2(N_IRQ) | Index of the line being acknowledged |
| pend_o | output | N_IRQ | Pending bit per line |
| irq_req | output | 1 | Level-sensitive, active-high request |

## Verification
A raw-line change is due on pend_o three rising edges after it is driven. A change on ack_valid or ack_idx takes effect at the next edge. A change on irq_en reaches irq_req with no edge at all. All stimulus is driven on the falling edge of the clock. The directed checks sample at falling edges, counting two edges (expecting no change yet) and then a third (expecting the change), or one edge for an acknowledge. Mask checks sample a short delay after the enable moves. During random traffic, a cycle-exact bench model holds the raw history and the acknowledge stream, and the bench compares pend_o and irq_req with that model at every falling edge.

// File: rtl/irq_acq_pkg.sv
// Package: shared encodings and the per-line detection rule for the
// interrupt acquisition stage.
// Assumes: the mode and polarity bits arrive as plain vectors from a register block.
package irq_acq_pkg;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_mode_e;

    typedef enum logic {
        POL_RISE = 1'b0,
        POL_FALL = 1'b1
    } edge_pol_e;

    // Decide whether one synchronized line shows an event this cycle.
    function automatic logic detect_bit(trig_mode_e mode, edge_pol_e pol,
                                        logic cur, logic old);
        logic hit;
        if (mode == TRIG_LEVEL) begin
            hit = cur;
        end else if (pol == POL_FALL) begin
            hit = old & ~cur;
        end else begin
            hit = cur & ~old;
        end
        return hit;
    endfunction

endpackage

// File: rtl/irq_sync.sv
// Module: irq_sync
// Brings a vector of asynchronous lines into the clock domain through a
// chain of STAGES registers per bit.
// Assumes: each source holds a level for at least two clocks.
module irq_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);

    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw lines in the first stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= d_in;
                end
            end else begin : g_next
                // Shift through the following stages.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_out = chain[STAGES-1];

endmodule

// File: rtl/irq_detect.sv
// Module: irq_detect
// Per-line event detection. The synchronized value is compared with a
// registered copy of itself to find an edge, or is used directly as a level.
// Assumes: sync_in is already in the clk domain.
module irq_detect
    import irq_acq_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_in,
    input  logic [W-1:0] trig_level,
    input  logic [W-1:0] edge_fall,
    output logic [W-1:0] evt
);

    logic [W-1:0] prev_q;

    // Keep the last synchronized value for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_in;
    end

    generate
        for (genvar i = 0; i < W; i++) begin : g_line
            // Apply the selected detection rule to line i.
            always_comb begin
                evt[i] = detect_bit(trig_mode_e'(trig_level[i]),
                                    edge_pol_e'(edge_fall[i]),
                                    sync_in[i], prev_q[i]);
            end
        end
    endgenerate

endmodule

// File: rtl/irq_pending.sv
// Module: irq_pending
// Pending bit per line. An event sets its bit, and an acknowledge of the
// matching index clears it. Setting wins over clearing. Bit 0 is held at zero.
// Assumes: ack_valid is a single-cycle strobe.
module irq_pending #(
    parameter int W     = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     evt,
    input  logic             ack_valid,
    input  logic [IDX_W-1:0] ack_idx,
    output logic [W-1:0]     pend
);

    logic [W-1:0] clr;

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            // Decode the acknowledge index for line i.
            always_comb clr[i] = ack_valid && (ack_idx == IDX_W'(i));

            if (i == 0) begin : g_tied
                // Line 0 is never driven and stays inactive.
                always_ff @(posedge clk) pend[i] <= 1'b0;
            end else begin : g_live
                // Set on event, otherwise clear on acknowledge.
                always_ff @(posedge clk) begin
                    if (!rst_n)      pend[i] <= 1'b0;
                    else if (evt[i]) pend[i] <= 1'b1;
                    else if (clr[i]) pend[i] <= 1'b0;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/irq_acq_stage.sv
// Module: irq_acq_stage (top)
// Synchronizes, detects and latches N_IRQ interrupt lines, then ORs the
// enabled pending bits into one active-high request.
// Assumes: configuration inputs change only while the affected line is idle.
module irq_acq_stage #(
    parameter int N_IRQ       = 96,
    parameter int SYNC_STAGES = 2,
    localparam int IDX_W      = $clog2(N_IRQ)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] irq_raw,
    input  logic [N_IRQ-1:0] trig_level,
    input  logic [N_IRQ-1:0] edge_fall,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             ack_valid,
    input  logic [IDX_W-1:0] ack_idx,
    output logic [N_IRQ-1:0] pend_o,
    output logic             irq_req
);

    logic [N_IRQ-1:0] raw_gated;
    logic [N_IRQ-1:0] sync_q;
    logic [N_IRQ-1:0] det_evt;

    // Tie line 0 inactive before it enters the synchronizer.
    always_comb begin
        raw_gated    = irq_raw;
        raw_gated[0] = 1'b0;
    end

    irq_sync #(.W(N_IRQ), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (raw_gated),
        .q_out (sync_q)
    );

    irq_detect #(.W(N_IRQ)) u_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_in    (sync_q),
        .trig_level (trig_level),
        .edge_fall  (edge_fall),
        .evt        (det_evt)
    );

    irq_pending #(.W(N_IRQ), .IDX_W(IDX_W)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (det_evt),
        .ack_valid (ack_valid),
        .ack_idx   (ack_idx),
        .pend      (pend_o)
    );

    // Raise the request while any enabled line is pending.
    always_comb irq_req = |(pend_o & irq_en);

endmodule

// File: rtl/irq_acq_stage_chk.sv
// Module: irq_acq_stage_chk
// Property checker bound into irq_acq_stage.
module irq_acq_stage_chk #(
    parameter int N_IRQ = 96,
    parameter int IDX_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_IRQ-1:0] irq_en,
    input logic             ack_valid,
    input logic [IDX_W-1:0] ack_idx,
    input logic [N_IRQ-1:0] evt,
    input logic [N_IRQ-1:0] pend,
    input logic             irq_req
);

    assert_idx0_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> !pend[0]);

    assert_no_spurious_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((pend & ~$past(pend) & ~$past(evt)) == '0));

    assert_event_latched_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (($past(evt) & ~pend) == '0));

    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && (int'(ack_idx) < N_IRQ) && !evt[ack_idx])
        |=> !pend[$past(ack_idx)]);

    assert_req_drop_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_req) |-> ($past(ack_valid) || ($past(irq_en) != irq_en)));

endmodule

bind irq_acq_stage irq_acq_stage_chk #(.N_IRQ(N_IRQ), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_en    (irq_en),
    .ack_valid (ack_valid),
    .ack_idx   (ack_idx),
    .evt       (det_evt),
    .pend      (pend_o),
    .irq_req   (irq_req)
);

// File: tb/irq_acq_stage_tb.sv
module irq_acq_stage_tb;
    localparam int N  = 96;
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_raw = '0, trig_level = '0, edge_fall = '0, irq_en = '0;
    logic          ack_valid = 1'b0;
    logic [IW-1:0] ack_idx = '0;
    logic [N-1:0]  pend_o;
    logic          irq_req;

    int  n_chk = 0, n_fail = 0;
    bit  model_on = 0, done = 0;
    logic [N-1:0] h1 = '0, h2 = '0, h3 = '0, mpend = '0;

    always #5 clk = ~clk;

    irq_acq_stage #(.N_IRQ(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_raw(irq_raw), .trig_level(trig_level),
        .edge_fall(edge_fall), .irq_en(irq_en), .ack_valid(ack_valid),
        .ack_idx(ack_idx), .pend_o(pend_o), .irq_req(irq_req)
    );

    // Expected event vector from the requirement rules (R3, R4, R5).
    function automatic logic [N-1:0] exp_evt(logic [N-1:0] cur, logic [N-1:0] old,
                                             logic [N-1:0] lvl, logic [N-1:0] fal);
        return (lvl & cur) | (~lvl & ~fal & cur & ~old) | (~lvl & fal & ~cur & old);
    endfunction

    function automatic logic [N-1:0] exp_clr(logic v, logic [IW-1:0] idx);
        logic [N-1:0] c = '0;
        if (v && int'(idx) < N) c[idx] = 1'b1;
        return c;
    endfunction

    // Reference model: raw history plus pending bits, advanced each edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            h1 <= '0; h2 <= '0; h3 <= '0; mpend <= '0;
        end else begin
            logic [N-1:0] e, nxt;
            e   = exp_evt(h2, h3, trig_level, edge_fall);
            nxt = (mpend & ~exp_clr(ack_valid, ack_idx)) | e;
            nxt[0] = 1'b0;
            mpend <= nxt;
            h3 <= h2; h2 <= h1;
            h1 <= {irq_raw[N-1:1], 1'b0};
        end
    end

    task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Model comparison at every falling edge once enabled.
    always @(negedge clk) begin
        if (model_on) begin
            check("R3/R4/R5/R6/R7 model pend", pend_o, mpend);
            check("R9 model req", N'(irq_req), N'(|(mpend & irq_en)));
        end
    end

    task automatic tick(int n = 1);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic ack(int idx);
        ack_valid = 1'b1; ack_idx = IW'(idx);
        tick();
        ack_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        irq_raw = '0;
        irq_raw[5] = 1'b1;
        tick(3);
        check("R1 reset pend", pend_o, '0);
        check("R1 reset req", N'(irq_req), '0);
        irq_raw = '0;
        rst_n = 1'b1;
        tick(4);

        // R2: latency of three edges on a default (rising edge) line.
        irq_raw[5] = 1'b1;
        tick(2);
        check("R2 not yet pending", N'(pend_o[5]), '0);
        tick();
        check("R2 pending at third edge", N'(pend_o[5]), N'(1));

        // R9: enable drives request, mask drops it at once.
        irq_en[5] = 1'b1; #1;
        check("R9 req on enable", N'(irq_req), N'(1));
        irq_en[5] = 1'b0; #1;
        check("R9 req off on mask", N'(irq_req), '0);
        check("R9 pending kept while masked", N'(pend_o[5]), N'(1));
        irq_en = '1;
        tick();

        // R7: out-of-range index ignored, matching index clears.
        ack(100);
        check("R7 out-of-range ack ignored", N'(pend_o[5]), N'(1));
        ack(5);
        check("R7 ack clears", N'(pend_o[5]), '0);
        tick(4);
        check("R6 held level no re-set", N'(pend_o[5]), '0);

        // R4: falling-edge polarity.
        edge_fall[7] = 1'b1;
        irq_raw[7] = 1'b1; tick(4);
        check("R4 rise ignored in fall mode", N'(pend_o[7]), '0);
        irq_raw[7] = 1'b0; tick(3);
        check("R4 fall detected", N'(pend_o[7]), N'(1));
        ack(7);

        // R3/R5: level mode re-raises while the source stays high.
        trig_level[9] = 1'b1;
        irq_raw[9] = 1'b1; tick(3);
        check("R3 level detected", N'(pend_o[9]), N'(1));
        ack(9);
        check("R5 still pending after ack", N'(pend_o[9]), N'(1));
        irq_raw[9] = 1'b0; tick(3);
        ack(9);
        check("R5 clears once source low", N'(pend_o[9]), '0);

        // R8: new event coincides with acknowledge.
        irq_raw[11] = 1'b1; tick(3);
        irq_raw[11] = 1'b0; tick(3);
        irq_raw[11] = 1'b1; tick(2);
        ack(11);
        check("R8 set wins over ack", N'(pend_o[11]), N'(1));
        ack(11);

        // R10: line 0 stays idle in level mode.
        trig_level[0] = 1'b1; irq_raw[0] = 1'b1; tick(5);
        check("R10 line 0 idle", N'(pend_o[0]), '0);
        tick(2);

        // Random traffic checked against the model.
        model_on = 1;
        for (int c = 0; c < 3000; c++) begin
            if (c % 250 == 0) begin
                trig_level = {$urandom, $urandom, $urandom};
                edge_fall  = {$urandom, $urandom, $urandom};
            end
            if ($urandom_range(0, 3) == 0)
                irq_raw = irq_raw ^ ({$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom});
            if ($urandom_range(0, 15) == 0) irq_en = {$urandom, $urandom, $urandom};
            ack_valid = ($urandom_range(0, 2) == 0);
            ack_idx   = IW'($urandom_range(0, 127));
            tick();
        end
        ack_valid = 1'b0;
        model_on = 0;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule